// File: doc/BRIEF.md
# Breathing PWM Duty Ramp Controller

This block drives a single PWM level that "breathes": across a programmable number of PWM periods its duty cycle climbs evenly from 0% to 100% and then falls evenly back to 0%. After each triangular sweep, the output is held inactive for a programmable number of clocks, and then the next sweep begins. The same output level feeds all three channel pins of the surrounding PWM instance. It is typically used to fade an LED in and out without software involvement.

Software writes the sweep length (in PWM periods) and the hold length (in clocks) into shadow registers. The active copies take new values only at the instant a sweep returns to 0% duty, so a running fade never jumps. While the block is disabled, the shadow values pass straight into the active copies. When the block is disabled or paused, the output drives a common stop level. A pause freezes the whole sequence, and the sequence resumes exactly where it stopped.

Top module: `breath_pwm`

## Requirements
- R1: While `en_i` is low, the output equals `stop_lvl_i`, and the sequence is reset so that the next enable starts a fresh sweep at counter position 0. Reset leaves the block in this state, with both shadow and active settings at their parameter defaults.
- R2: With period P = `period_i`, span N and H = floor(N/2), sweep period k (0 ≤ k < N) uses level L = k when k ≤ H, otherwise N−k. The output is high for the first floor(P·L/H) clocks of that period and low for the rest.
- R3: In sweep period k = H, the output is high for the whole PWM period (100% duty).
- R4: After the last sweep period, the output is low for exactly the committed hold count of clocks, and then a new sweep starts at level 0. A hold count of 0 starts the next sweep on the following clock.
- R5: A committed span below 2 keeps the output low for as long as the block runs.
- R6: While `pause_i` is high and `en_i` is high, the output equals `stop_lvl_i` and no counter advances. After the pause is released, the waveform continues from the position it had reached.
- R7: A span or hold write while running changes nothing until the current sweep ends. At that instant both values are committed, and the new hold count governs the hold that follows immediately.
- R8: Span and hold values written while disabled take effect from the first period after enable.
- R9: While running and not paused, `stop_lvl_i` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low stops the block and resets the sequence |
| pause_i | input | 1 | Freezes the sequence and drives the stop level |
| stop_lvl_i | input | 1 | Output level while disabled or paused |
| period_i | input | 16 | PWM period in clocks |
| span_wr_i | input | 1 | Write strobe for the sweep-length shadow register |
| span_wdata_i | input | 16 | Sweep length in PWM periods (up and down) |
| hold_wr_i | input | 1 | Write strobe for the hold shadow register |
| hold_wdata_i | input | 24 | Hold length in clocks |
| pwm_o | output | 1 | Shared PWM output level |

## Verification
The bench sweeps small periods against every span from 0 to 8 (including odd spans) and against hold counts of zero, one and several. It computes the expected level of every clock from the closed-form ramp, so an off-by-one in the turn-around step or the hold length shifts the waveform and is reported. One run rewrites the span and hold in the middle of a sweep. A design that commits these at once would bend the current ramp, and a design that commits late would apply the old hold. Pausing mid-ramp catches a counter that keeps running while the output is frozen. Spans of 0 and 1 catch a divider that is left unguarded.

// File: rtl/breath_pkg.sv
package breath_pkg;

    localparam int PRD_W  = 16;
    localparam int SPAN_W = 16;
    localparam int HOLD_W = 24;
    localparam int PROD_W = PRD_W + SPAN_W;

    typedef enum logic {
        PH_SWEEP = 1'b0,
        PH_HOLD  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [SPAN_W-1:0] span;
        logic [HOLD_W-1:0] hold;
    } breath_cfg_t;

    typedef struct packed {
        phase_e            phase;
        logic [PRD_W-1:0]  cnt;
        logic [SPAN_W-1:0] step;
        logic [HOLD_W-1:0] hcnt;
        logic [PRD_W-1:0]  duty;
    } seq_state_t;

    // Triangle level for a sweep position: rises to half, then falls.
    function automatic logic [SPAN_W-1:0] tri_level(
        input logic [SPAN_W-1:0] step,
        input logic [SPAN_W-1:0] span
    );
        logic [SPAN_W-1:0] half;
        half = span >> 1;
        return (step <= half) ? step : (span - step);
    endfunction

endpackage

// File: rtl/breath_shadow.sv
module breath_shadow
    import breath_pkg::*;
#(
    parameter logic [SPAN_W-1:0] SPAN_RST = '0,
    parameter logic [HOLD_W-1:0] HOLD_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              commit,
    input  logic              span_wr,
    input  logic [SPAN_W-1:0] span_wdata,
    input  logic              hold_wr,
    input  logic [HOLD_W-1:0] hold_wdata,
    output logic [HOLD_W-1:0] hold_next,
    output breath_cfg_t       act_o
);

    breath_cfg_t sh_q;
    breath_cfg_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '{span: SPAN_RST, hold: HOLD_RST};
            act_q <= '{span: SPAN_RST, hold: HOLD_RST};
        end else begin
            if (span_wr) sh_q.span <= span_wdata;
            if (hold_wr) sh_q.hold <= hold_wdata;
            // Idle: follow shadow freely; running: only at sweep end.
            if (!en || commit) act_q <= sh_q;
        end
    end

    assign hold_next = sh_q.hold;
    assign act_o     = act_q;

    // R7: active settings never move mid-sweep while running
    p_commit_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (en && !commit) |=> (act_q == $past(act_q)));

endmodule

// File: rtl/breath_ramp.sv
module breath_ramp
    import breath_pkg::*;
(
    input  logic [PRD_W-1:0]  period,
    input  logic [SPAN_W-1:0] span,
    input  logic [SPAN_W-1:0] step,
    output logic [PRD_W-1:0]  duty
);

    logic [SPAN_W-1:0] half;
    logic [SPAN_W-1:0] level;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        half  = span >> 1;
        level = tri_level(step, span);
        prod  = PROD_W'(period) * PROD_W'(level);
        quot  = (half == '0) ? '0 : prod / PROD_W'(half);
        duty  = PRD_W'(quot);
    end

    // R3: scaled duty never exceeds one full period
    always_comb begin
        if (half != '0 && level <= half) begin
            p_duty_bound_r3: assert (quot <= PROD_W'(period));
        end
    end

endmodule

// File: rtl/breath_seq.sv
module breath_seq
    import breath_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pause,
    input  logic [PRD_W-1:0]  period,
    input  breath_cfg_t       act,
    input  logic [HOLD_W-1:0] hold_next,
    input  logic [PRD_W-1:0]  duty_next,
    output logic [SPAN_W-1:0] step_next,
    output logic              commit,
    output logic              active
);

    seq_state_t st;

    logic              run;
    logic [PRD_W-1:0]  prd_last;
    logic              period_end;
    logic              zero_cfg;
    logic              last_step;
    logic [SPAN_W-1:0] span_m1;

    always_comb begin
        run        = en && !pause;
        prd_last   = (period == '0) ? '0 : period - 1'b1;
        period_end = st.cnt >= prd_last;
        zero_cfg   = act.span < SPAN_W'(2);
        span_m1    = act.span - 1'b1;
        last_step  = zero_cfg || (st.step >= span_m1);
        step_next  = last_step ? '0 : st.step + 1'b1;
        commit     = run && (st.phase == PH_SWEEP) && period_end && last_step;
        active     = (st.phase == PH_SWEEP) && (st.cnt < st.duty);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st <= '{phase: PH_SWEEP, cnt: '0, step: '0, hcnt: '0, duty: '0};
        end else if (run) begin
            unique case (st.phase)
                PH_SWEEP: begin
                    if (period_end) begin
                        st.cnt <= '0;
                        if (last_step) begin
                            st.step <= '0;
                            st.duty <= '0;
                            st.hcnt <= '0;
                            if (hold_next != '0) st.phase <= PH_HOLD;
                        end else begin
                            st.step <= step_next;
                            st.duty <= duty_next;
                        end
                    end else begin
                        st.cnt <= st.cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (st.hcnt >= act.hold - 1'b1) begin
                        st.phase <= PH_SWEEP;
                        st.hcnt  <= '0;
                    end else begin
                        st.hcnt <= st.hcnt + 1'b1;
                    end
                end
                default: st.phase <= PH_SWEEP;
            endcase
        end
    end

    // R1: disabling returns the sequence to its start
    p_idle_clears_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st.cnt == '0 && st.step == '0 && st.phase == PH_SWEEP));

    // R6: a paused cycle advances nothing
    p_pause_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (en && pause) |=> ($stable(st.cnt) && $stable(st.step) && $stable(st.hcnt)));

    // R4: hold counter stays inside the committed hold length
    p_hold_len_r4: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_HOLD) |-> (st.hcnt < act.hold));

    // R5: a degenerate span never produces a nonzero duty
    p_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (en && act.span < SPAN_W'(2)) |-> (st.duty == '0));

    // R2: period counter stays inside the PWM period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        (en && st.phase == PH_SWEEP && period != '0) |-> (st.cnt < period));

endmodule

// File: rtl/breath_pwm.sv
module breath_pwm
    import breath_pkg::*;
#(
    parameter logic [SPAN_W-1:0] SPAN_RST = '0,
    parameter logic [HOLD_W-1:0] HOLD_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              pause_i,
    input  logic              stop_lvl_i,
    input  logic [PRD_W-1:0]  period_i,
    input  logic              span_wr_i,
    input  logic [SPAN_W-1:0] span_wdata_i,
    input  logic              hold_wr_i,
    input  logic [HOLD_W-1:0] hold_wdata_i,
    output logic              pwm_o
);

    breath_cfg_t       act_cfg;
    logic [HOLD_W-1:0] hold_next;
    logic [SPAN_W-1:0] step_next;
    logic [PRD_W-1:0]  duty_next;
    logic              commit;
    logic              active;

    breath_shadow #(
        .SPAN_RST (SPAN_RST),
        .HOLD_RST (HOLD_RST)
    ) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .en         (en_i),
        .commit     (commit),
        .span_wr    (span_wr_i),
        .span_wdata (span_wdata_i),
        .hold_wr    (hold_wr_i),
        .hold_wdata (hold_wdata_i),
        .hold_next  (hold_next),
        .act_o      (act_cfg)
    );

    breath_ramp u_ramp (
        .period (period_i),
        .span   (act_cfg.span),
        .step   (step_next),
        .duty   (duty_next)
    );

    breath_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en_i),
        .pause     (pause_i),
        .period    (period_i),
        .act       (act_cfg),
        .hold_next (hold_next),
        .duty_next (duty_next),
        .step_next (step_next),
        .commit    (commit),
        .active    (active)
    );

    assign pwm_o = (!en_i || pause_i) ? stop_lvl_i : active;

endmodule

// File: tb/breath_pwm_bench.sv
module breath_pwm_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        pause = 1'b0;
    logic        stop_level = 1'b0;
    logic [15:0] prd = 16'd4;
    logic        br_wr = 1'b0;
    logic [15:0] br_wdata = '0;
    logic        hold_wr = 1'b0;
    logic [23:0] hold_wdata = '0;
    logic        pwm_o;

    int    n_tests = 0;
    int    n_fail = 0;
    int    tact = 0;
    string cur_req = "AUTO";
    // model configuration
    int m_p = 4, m_n = 0, m_h = 0;
    bit sw_on = 0;
    int m_n2 = 0, m_h2 = 0;

    breath_pwm u_breath_pwm (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .pause_i      (pause),
        .stop_lvl_i   (stop_level),
        .period_i     (prd),
        .span_wr_i    (br_wr),
        .span_wdata_i (br_wdata),
        .hold_wr_i    (hold_wr),
        .hold_wdata_i (hold_wdata),
        .pwm_o        (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit core(input int t, input int p, input int n, input int hd,
                                output string rg);
        int cyc, pos, k, c, h, lv;
        if (n < 2) begin rg = "R5"; return 1'b0; end
        cyc = n * p + hd;
        pos = t % cyc;
        if (pos >= n * p) begin rg = "R4"; return 1'b0; end
        k  = pos / p;
        c  = pos % p;
        h  = n / 2;
        lv = (k <= h) ? k : n - k;
        rg = (k == h) ? "R3" : "R2";
        return c < (p * lv) / h;
    endfunction

    function automatic bit model(input int t, output string rg);
        int t2;
        if (sw_on && t >= m_n * m_p) begin
            t2 = t - m_n * m_p;
            if (t2 < m_h2) begin rg = "R4"; return 1'b0; end
            return core(t2 - m_h2, m_p, m_n2, m_h2, rg);
        end
        return core(t, m_p, m_n, m_h, rg);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0b expected=%0b", req, tact, act, exp);
        end
    endtask

    task automatic cycle();
        logic  e;
        string rg;
        if (!en) tact = 0;
        else if (!pause) tact++;
        @(negedge clk);
        #1;
        if (!en) begin e = stop_level; rg = "R1"; end
        else if (pause) begin e = stop_level; rg = "R6"; end
        else e = model(tact, rg);
        check((cur_req == "AUTO") ? rg : cur_req, pwm_o, e);
    endtask

    task automatic configure(input int p, input int n, input int hd);
        en = 1'b0;
        prd = 16'(p);
        br_wr = 1'b1; br_wdata = 16'(n);
        hold_wr = 1'b1; hold_wdata = 24'(hd);
        cycle();
        br_wr = 1'b0; hold_wr = 1'b0;
        cycle();
        cycle();
        m_p = p; m_n = n; m_h = hd; sw_on = 0;
    endtask

    task automatic run_cycles(input int cnt);
        for (int i = 0; i < cnt; i++) cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int plist[3] = '{3, 4, 8};
        int hlist[3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state follows stop level while disabled
        stop_level = 1'b1; cur_req = "R1"; cycle();
        stop_level = 1'b0; cycle();
        cur_req = "AUTO";

        // R2 R3 R4 R5 R9: near-exhaustive sweep of small configurations
        for (int pi = 0; pi < 3; pi++) begin
            for (int n = 0; n <= 8; n++) begin
                for (int hi = 0; hi < 3; hi++) begin
                    configure(plist[pi], n, hlist[hi]);
                    stop_level = 1'(n + hi);
                    en = 1'b1;
                    run_cycles(2 * (((n < 2) ? 2 : n) * plist[pi] + hlist[hi]) + 5);
                    en = 1'b0;
                    cur_req = "R1"; cycle(); cur_req = "AUTO";
                end
            end
        end

        // R7: mid-sweep rewrite commits only at sweep end
        configure(8, 8, 2);
        en = 1'b1;
        run_cycles(9);
        m_n2 = 4; m_h2 = 5; sw_on = 1;
        br_wr = 1'b1; br_wdata = 16'd4;
        hold_wr = 1'b1; hold_wdata = 24'd5;
        cur_req = "R7";
        cycle();
        br_wr = 1'b0; hold_wr = 1'b0;
        run_cycles(64 + 2 * (4 * 8 + 5));
        cur_req = "AUTO";

        // R6: pause freezes the sequence and drives stop level
        configure(8, 4, 3);
        en = 1'b1;
        run_cycles(13);
        pause = 1'b1; stop_level = 1'b1;
        run_cycles(6);
        stop_level = 1'b0;
        run_cycles(3);
        pause = 1'b0;
        cur_req = "R6";
        run_cycles(2 * (4 * 8 + 3));
        cur_req = "AUTO";

        // R8: settings written while idle apply right after enable
        en = 1'b0; cycle();
        cur_req = "R8";
        configure(4, 6, 1);
        en = 1'b1;
        run_cycles(2 * (6 * 4 + 1) + 3);
        en = 1'b0;
        cycle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule